// File: doc/BRIEF.md
# Tower Word Serialiser with Playback Memory

The block sits between the deserialisers of trigger-tower data and the cluster-finding logic. Each channel receives one 10-bit tower word per bunch crossing and sends it out again over a 3-bit lane at four times the crossing rate. The output comes out as four beats per crossing, most significant bits first. The block runs on the fast clock. An internal beat counter splits the clock into crossings, and a one-cycle framing marker shows where each crossing starts.

Each channel owns one dual-port memory. In live mode every incoming word is also written into this memory, which forms a circular pipeline that a readout path can query by "crossings ago". In playback mode the lane sends the preloaded memory contents in a loop instead of live input, so downstream logic can be exercised without external links. A calibration mode sends a fixed two-word alternating pattern that downstream chips use to align their inputs. A mute mode sends zeros. The host preloads the memory through a write port when the block is not in live mode.

Top module: `tower_serialiser`

## Requirements
- R1: After reset is released, `frame_o` is high in the first cycle and every lane outputs zero for the whole first crossing.
- R2: `frame_o` is high in exactly one cycle of every four. That cycle carries beat 0 of a crossing.
- R3: In live mode (`mode_i` = 00) the word on a channel's `din_i` slice is sampled in the cycle three after `frame_o`. It then appears on that channel's `ser_o` slice during the next crossing as beats {d[9:7]}, {d[6:4]}, {d[3:1]}, {d[0],2'b00}, in that order.
- R4: Each live crossing writes its input word into the channel memory at the write pointer. The pointer then advances by one and wraps at DEPTH.
- R5: `rd_back_i` = n, held in a `frame_o` cycle, makes `rd_data_o` show in the following cycle the word stored n+1 writes ago (n = 0 is the newest).
- R6: A host write (`cfg_we_i`, `cfg_ch_i`, `cfg_addr_i`, `cfg_data_i`) held in a `frame_o` cycle is stored when the crossing's latched mode is not live. In live mode it is ignored.
- R7: In playback mode (`mode_i` = 01) a channel sends memory entries 0, 1, ..., `play_last_i` and then starts again at 0. Entry 0 is always sent first after entering playback from any other mode.
- R8: In calibration mode (`mode_i` = 10) every channel sends CAL_A (default 10'h2AA) and CAL_B (10'h155) on alternate crossings, starting with CAL_A.
- R9: In mute mode (`mode_i` = 11) the lanes send zero. In every non-live mode the memory is not written by input data and the write pointer holds.
- R10: `mode_i` is latched only at the crossing boundary. Changes that are reverted before the last beat cycle have no effect on the output.
- R11: Channels are independent: each sends its own input, and a host write reaches only the channel named by `cfg_ch_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four cycles per crossing |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 00 live, 01 playback, 10 calibration, 11 mute |
| din_i | input | N_CH*WORD_W | Parallel tower words, channel 0 in the low bits |
| play_last_i | input | AW | Index of the last entry of the playback loop |
| cfg_we_i | input | 1 | Host write strobe |
| cfg_ch_i | input | CH_W | Channel selected by the host write |
| cfg_addr_i | input | AW | Host write address |
| cfg_data_i | input | WORD_W | Host write data |
| rd_back_i | input | AW | Lookback distance for the readout read |
| ser_o | output | N_CH*BEAT_W | Serial lanes, one beat per cycle |
| frame_o | output | 1 | High during beat 0 of each crossing |
| rd_data_o | output | N_CH*WORD_W | Readout data from each channel memory |

## Verification
The embedded properties assume that `mode_i` is valid in the last beat cycle of a crossing. They also assume DEPTH is a power of two, so the lookback wraps through plain pointer arithmetic. The bench drives every input on the falling edge and changes modes and data only in `frame_o` cycles. The one exception is the deliberate mid-crossing mode toggle, which the bench reverts before the latching cycle. Host writes are placed in `frame_o` cycles, where no live write can collide with them. Readout data is taken only in the cycle after `frame_o`, because the read port serves the playback fetch one cycle later.

// File: rtl/tser_pkg.sv
package tser_pkg;
  typedef enum logic [1:0] {
    MODE_LIVE = 2'b00,
    MODE_PLAY = 2'b01,
    MODE_CAL  = 2'b10,
    MODE_MUTE = 2'b11
  } mode_e;
endpackage

// File: rtl/tser_ram.sv
module tser_ram #(
  parameter int W = 10,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // registered read port (read-first)
  always_ff @(posedge clk) begin
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/tser_xing_ctrl.sv
module tser_xing_ctrl
  import tser_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_e            mode_i,
  input  logic [AW-1:0]    play_last_i,
  input  logic [AW-1:0]    rd_back_i,
  output logic [CNT_W-1:0] beat_o,
  output logic             boundary_o,
  output mode_e            mode_q_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic             live_wr_o,
  output logic             cal_sel_o,
  output logic [AW-1:0]    rd_addr_o
);
  logic [AW-1:0] play_ptr;

  assign boundary_o = (beat_o == CNT_W'(BEATS-1));
  assign live_wr_o  = boundary_o && (mode_i == MODE_LIVE);

  // one beat before the boundary the read port fetches the playback entry
  assign rd_addr_o = (beat_o == CNT_W'(BEATS-2)) ? play_ptr
                                                 : AW'(wr_ptr_o - rd_back_i - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_o    <= '0;
      mode_q_o  <= MODE_MUTE;
      wr_ptr_o  <= '0;
      play_ptr  <= '0;
      cal_sel_o <= 1'b0;
    end else begin
      beat_o <= boundary_o ? '0 : beat_o + 1'b1;
      if (boundary_o) begin
        mode_q_o <= mode_i;
        if (mode_i == MODE_LIVE) wr_ptr_o <= wr_ptr_o + 1'b1;
        if (mode_i == MODE_PLAY)
          play_ptr <= (play_ptr == play_last_i) ? '0 : play_ptr + 1'b1;
        else
          play_ptr <= '0;
        cal_sel_o <= (mode_i == MODE_CAL) ? ~cal_sel_o : 1'b0;
      end
    end
  end

  initial assert (DEPTH == (1 << AW)) else $error("DEPTH must be a power of two");

  // R10: the latched mode only moves at a crossing boundary
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !boundary_o |=> $stable(mode_q_o));

  // R4: a live crossing advances the write pointer by one (wrapping)
  p_wr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (boundary_o && mode_i == MODE_LIVE) |=> wr_ptr_o == AW'($past(wr_ptr_o) + 1'b1));

  // R9: outside live crossings the write pointer holds
  p_wr_freeze_r9: assert property (@(posedge clk) disable iff (rst)
    !(boundary_o && mode_i == MODE_LIVE) |=> $stable(wr_ptr_o));

  // R7: the playback loop returns to entry 0 after the last entry
  p_play_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (boundary_o && mode_i == MODE_PLAY && play_ptr == play_last_i) |=> play_ptr == '0);
endmodule

// File: rtl/tser_lane.sv
module tser_lane
  import tser_pkg::*;
#(
  parameter int W = 10,
  parameter int BEATS = 4,
  parameter logic [W-1:0] CAL_A = 10'h2AA,
  parameter logic [W-1:0] CAL_B = 10'h155,
  localparam int BEAT_W = (W + BEATS - 1) / BEATS,
  localparam int PAD_W = BEAT_W * BEATS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  mode_e             mode_sel_i,
  input  mode_e             mode_q_i,
  input  logic [W-1:0]      live_i,
  input  logic [W-1:0]      play_i,
  input  logic              cal_sel_i,
  output logic [BEAT_W-1:0] ser_o
);
  logic [W-1:0]     word_next;
  logic [PAD_W-1:0] shreg;

  always_comb begin
    unique case (mode_sel_i)
      MODE_LIVE: word_next = live_i;
      MODE_PLAY: word_next = play_i;
      MODE_CAL:  word_next = cal_sel_i ? CAL_B : CAL_A;
      default:   word_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             shreg <= '0;
    else if (boundary_i) shreg <= PAD_W'(word_next) << (PAD_W - W);
    else                 shreg <= shreg << BEAT_W;
  end

  assign ser_o = shreg[PAD_W-1 -: BEAT_W];

  // R9: a muted crossing carries only zero beats
  p_mute_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_q_i == MODE_MUTE) |-> ser_o == '0);
endmodule

// File: rtl/tower_serialiser.sv
module tower_serialiser
  import tser_pkg::*;
#(
  parameter int N_CH = 2,
  parameter int WORD_W = 10,
  parameter int BEATS = 4,
  parameter int DEPTH = 16,
  parameter logic [WORD_W-1:0] CAL_A = 10'h2AA,
  parameter logic [WORD_W-1:0] CAL_B = 10'h155,
  localparam int AW = $clog2(DEPTH),
  localparam int BEAT_W = (WORD_W + BEATS - 1) / BEATS,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_i,
  input  logic [N_CH*WORD_W-1:0]   din_i,
  input  logic [AW-1:0]            play_last_i,
  input  logic                     cfg_we_i,
  input  logic [CH_W-1:0]          cfg_ch_i,
  input  logic [AW-1:0]            cfg_addr_i,
  input  logic [WORD_W-1:0]        cfg_data_i,
  input  logic [AW-1:0]            rd_back_i,
  output logic [N_CH*BEAT_W-1:0]   ser_o,
  output logic                     frame_o,
  output logic [N_CH*WORD_W-1:0]   rd_data_o
);
  mode_e            mode_in, mode_q;
  logic [CNT_W-1:0] beat;
  logic             boundary, live_wr, cal_sel;
  logic [AW-1:0]    wr_ptr, rd_addr;

  assign mode_in = mode_e'(mode_i);
  assign frame_o = (beat == '0);

  tser_xing_ctrl #(.BEATS(BEATS), .DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst(rst), .mode_i(mode_in), .play_last_i(play_last_i),
    .rd_back_i(rd_back_i), .beat_o(beat), .boundary_o(boundary),
    .mode_q_o(mode_q), .wr_ptr_o(wr_ptr), .live_wr_o(live_wr),
    .cal_sel_o(cal_sel), .rd_addr_o(rd_addr)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic              host_we, we;
    logic [AW-1:0]     waddr;
    logic [WORD_W-1:0] wdata, q, live_word;

    assign live_word = din_i[g*WORD_W +: WORD_W];
    // host writes only outside live mode; a live write always wins the port
    assign host_we = cfg_we_i && (cfg_ch_i == CH_W'(g)) &&
                     (mode_q != MODE_LIVE) && !live_wr;
    assign we    = live_wr || host_we;
    assign waddr = live_wr ? wr_ptr : cfg_addr_i;
    assign wdata = live_wr ? live_word : cfg_data_i;

    tser_ram #(.W(WORD_W), .DEPTH(DEPTH)) ram_i (
      .clk(clk), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
      .raddr_i(rd_addr), .rdata_o(q)
    );

    tser_lane #(.W(WORD_W), .BEATS(BEATS), .CAL_A(CAL_A), .CAL_B(CAL_B)) lane_i (
      .clk(clk), .rst(rst), .boundary_i(boundary), .mode_sel_i(mode_in),
      .mode_q_i(mode_q), .live_i(live_word), .play_i(q), .cal_sel_i(cal_sel),
      .ser_o(ser_o[g*BEAT_W +: BEAT_W])
    );

    assign rd_data_o[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: tb/tower_serialiser_tb.sv
module tower_serialiser_tb_top;
  import tser_pkg::*;

  localparam int CLK_P  = 10;
  localparam int N_CH   = 2;
  localparam int W      = 10;
  localparam int BEATS  = 4;
  localparam int DEPTH  = 16;
  localparam int AW     = 4;
  localparam int BEAT_W = 3;
  localparam int PAD_W  = 12;
  localparam logic [W-1:0] CAL_A = 10'h2AA;
  localparam logic [W-1:0] CAL_B = 10'h155;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'b11;
  logic [N_CH*W-1:0] din = '0;
  logic [AW-1:0] play_last = '0;
  logic cfg_we = 1'b0;
  logic cfg_ch = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [W-1:0] cfg_data = '0;
  logic [AW-1:0] rd_back = '0;
  logic [N_CH*BEAT_W-1:0] ser_o;
  logic frame_o;
  logic [N_CH*W-1:0] rd_data;

  always #(CLK_P/2) clk = ~clk;

  tower_serialiser dut_i (
    .clk(clk), .rst(rst), .mode_i(mode_i), .din_i(din), .play_last_i(play_last),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_addr_i(cfg_addr),
    .cfg_data_i(cfg_data), .rd_back_i(rd_back), .ser_o(ser_o),
    .frame_o(frame_o), .rd_data_o(rd_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model
  logic [W-1:0] mem_m [N_CH][DEPTH];
  logic [W-1:0] exp_w [N_CH];
  logic [AW-1:0] wr_m = '0;
  logic [AW-1:0] pp_m = '0;
  bit cal_m = 1'b0;
  mode_e prev_mode = MODE_MUTE;
  bit wr_pend = 1'b0;
  bit wr_ch = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  bit rd_chk = 1'b0;
  string rd_tag = "R5 lookback read";
  bit glitch = 1'b0;
  mode_e glitch_mode = MODE_CAL;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One crossing: entered and left at the falling edge inside a frame_o cycle.
  // Drives the inputs for the coming boundary and checks the word emitted now.
  task automatic xing(input mode_e m, input logic [W-1:0] d0, input logic [W-1:0] d1,
                      input string req);
    logic [PAD_W-1:0] got [N_CH];
    logic [W-1:0] dv [N_CH];
    dv[0] = d0;
    dv[1] = d1;
    mode_i   = m;
    din      = {d1, d0};
    cfg_we   = wr_pend;
    cfg_ch   = wr_ch;
    cfg_addr = wr_addr;
    cfg_data = wr_data;
    for (int k = 0; k < BEATS; k++) begin
      if (k > 0) @(negedge clk);
      chk(frame_o == (k == 0), "R2 frame marker", frame_o, (k == 0));
      for (int c = 0; c < N_CH; c++)
        got[c][PAD_W-1-k*BEAT_W -: BEAT_W] = ser_o[c*BEAT_W +: BEAT_W];
      if (k == 1) begin
        cfg_we = 1'b0;
        if (rd_chk)
          for (int c = 0; c < N_CH; c++)
            chk(rd_data[c*W +: W] == mem_m[c][AW'(wr_m - rd_back - 1'b1)], rd_tag,
                rd_data[c*W +: W], mem_m[c][AW'(wr_m - rd_back - 1'b1)]);
        if (wr_pend && prev_mode != MODE_LIVE) mem_m[wr_ch][wr_addr] = wr_data;
        wr_pend = 1'b0;
        if (glitch) mode_i = glitch_mode;
      end
      if (k == 2) mode_i = m;
    end
    for (int c = 0; c < N_CH; c++)
      chk(got[c] == {exp_w[c], 2'b00}, req, got[c], {exp_w[c], 2'b00});
    // boundary model
    for (int c = 0; c < N_CH; c++) begin
      case (m)
        MODE_LIVE: begin exp_w[c] = dv[c]; mem_m[c][wr_m] = dv[c]; end
        MODE_PLAY: exp_w[c] = mem_m[c][pp_m];
        MODE_CAL:  exp_w[c] = cal_m ? CAL_B : CAL_A;
        default:   exp_w[c] = '0;
      endcase
    end
    if (m == MODE_LIVE) wr_m = wr_m + 1'b1;
    pp_m  = (m == MODE_PLAY) ? ((pp_m == play_last) ? '0 : pp_m + 1'b1) : '0;
    cal_m = (m == MODE_CAL) ? ~cal_m : 1'b0;
    prev_mode = m;
    glitch = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(frame_o == 1'b1, "R1 frame after reset", frame_o, 1);
    xing(MODE_MUTE, '0, '0, "R1 reset output zero");
    xing(MODE_MUTE, 10'h3C3, 10'h0F0, "R9 mute output zero");
  endtask

  task automatic t_live();
    for (int i = 0; i < 20; i++)
      xing(MODE_LIVE, W'(i*37 + 5), W'(~(i*37 + 5)), "R3 live serial word (R11 per channel)");
  endtask

  task automatic t_lookback();
    int backs [4] = '{0, 1, 5, 15};
    rd_chk = 1'b1;
    rd_tag = "R5 lookback read (R4 wrap)";
    for (int i = 0; i < 4; i++) begin
      rd_back = AW'(backs[i]);
      xing(MODE_LIVE, W'(i*101 + 9), W'(i*53 + 700), "R3 live serial word");
    end
    rd_chk = 1'b0;
  endtask

  task automatic t_glitch();
    glitch = 1'b1;
    glitch_mode = MODE_CAL;
    xing(MODE_LIVE, 10'h2F1, 10'h10E, "R3 live serial word");
    glitch = 1'b1;
    glitch_mode = MODE_MUTE;
    xing(MODE_LIVE, 10'h0A5, 10'h35A, "R10 mid-crossing mode change ignored");
  endtask

  task automatic t_host_ignored_live();
    wr_pend = 1'b1; wr_ch = 1'b0; wr_addr = 4'd2; wr_data = 10'h3FF;
    xing(MODE_MUTE, '0, '0, "R10 mid-crossing mode change ignored");
    rd_chk = 1'b1;
    rd_tag = "R6 host write ignored in live mode";
    rd_back = AW'(wr_m - 4'd3);
    xing(MODE_MUTE, 10'h111, 10'h222, "R9 mute output zero");
    rd_chk = 1'b0;
  endtask

  task automatic t_host_writes();
    for (int a = 0; a < 4; a++) begin
      wr_pend = 1'b1; wr_ch = 1'b0; wr_addr = AW'(a); wr_data = W'(10'h100 + a*17);
      xing(MODE_MUTE, '0, '0, "R9 mute output zero");
    end
    wr_pend = 1'b1; wr_ch = 1'b1; wr_addr = 4'd0; wr_data = 10'h0F0;
    xing(MODE_MUTE, '0, '0, "R9 mute output zero");
    rd_chk = 1'b1;
    rd_tag = "R6 host write stored (R11 channel select)";
    rd_back = AW'(wr_m - 4'd1);
    xing(MODE_MUTE, '0, '0, "R9 mute output zero");
    rd_back = AW'(wr_m - 4'd3);
    xing(MODE_MUTE, '0, '0, "R9 mute output zero");
    rd_chk = 1'b0;
  endtask

  task automatic t_playback();
    play_last = 4'd3;
    for (int i = 0; i < 9; i++)
      xing(MODE_PLAY, 10'h155, 10'h2AA, "R7 playback loop");
    xing(MODE_CAL, '0, '0, "R7 playback loop");
    for (int i = 0; i < 3; i++)
      xing(MODE_PLAY, '0, '0, "R7 playback restart after other mode");
  endtask

  task automatic t_cal();
    for (int i = 0; i < 5; i++)
      xing(MODE_CAL, 10'h3AB, 10'h001, "R8 calibration pattern");
    xing(MODE_MUTE, '0, '0, "R8 calibration pattern");
    xing(MODE_MUTE, '0, '0, "R9 mute output zero");
  endtask

  initial begin
    for (int c = 0; c < N_CH; c++) begin
      exp_w[c] = '0;
      for (int a = 0; a < DEPTH; a++) mem_m[c][a] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_live();
    t_lookback();
    t_glitch();
    t_host_ignored_live();
    t_host_writes();
    t_playback();
    t_cal();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule